// File: doc/BRIEF.md
# Scatter-Gather Descriptor Encoder

This block converts one transfer request, held as two short lists of buffers (one list of sources, one of destinations, each entry a 48-bit address and a byte length), into an ordered stream of 64-bit transfer descriptors. Before any descriptor leaves, the block checks that every length can be encoded and announces how many descriptors the request will produce. Each buffer is written either as a byte-length descriptor or, when its length is a whole number of 16-byte units, as a large-format descriptor that carries the unit count. Destination descriptors are interleaved with source descriptors. Each source is followed by the destinations that consume its bytes, and any destinations left once the sources run out follow at the end.

Software or an upstream engine fills the two lists through a write port while the block is idle. It then pulses `start` with the two entry counts. The block moves through named states. IDLE goes to SCAN on start, or straight to COUNT for an empty request, or to FAIL when a count is too large. SCAN checks one entry per cycle and goes to FAIL on an illegal length, otherwise to COUNT. COUNT presents the total and picks the first emit state. EMIT_SRC and EMIT_DST each hold one descriptor until it is accepted, then pick the next emit state or FIN. FIN and FAIL each last one cycle and return to IDLE.

Top module: `sg_desc_encoder`

## Requirements
- R1: A source buffer whose length is not a multiple of 16 produces a word with type 2 in bits 63:60, the byte length in bits 59:44 and address bits 43:0 in bits 43:0. Address bits 47:44 are dropped.
- R2: A destination buffer whose length is not a multiple of 16 produces the same layout with type 3.
- R3: A buffer whose length is a multiple of 16, zero included, produces type 6 (source) or 7 (destination), with the length divided by 16 in bits 59:44.
- R4: A request is rejected when any byte length that is not a multiple of 16 exceeds 0xFFFF, when any multiple-of-16 length exceeds 0xFFFF0, or when either count exceeds the list depth. A rejected request raises `req_err` and `done` together for one cycle, with no `total_valid` and no descriptor.
- R5: Each source descriptor is followed by destination descriptors while its remaining byte target is non-zero. A shorter destination subtracts its length from the target, and an equal or longer one clears the target.
- R6: After the last source descriptor, every destination not yet emitted follows in list order.
- R7: `total_valid` pulses for one cycle with `total_cnt` equal to the number of descriptors the stream will carry. This happens before the first descriptor is valid.
- R8: A request with zero sources and zero destinations gives a total of 0, emits no descriptor and then signals `done`.
- R9: While `d_valid` is high and `d_ready` is low, `d_valid` stays high and `d_data` holds its value.
- R10: List writes and `start` pulses that arrive while `busy` is high are ignored.
- R11: After reset `busy`, `d_valid`, `total_valid`, `done` and `req_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write one list entry |
| wr_sel | input | 1 | List select: 0 source, 1 destination |
| wr_idx | input | IDX_W | Entry index |
| wr_addr | input | ADDR_W | Buffer address |
| wr_len | input | LEN_W | Buffer length in bytes |
| start | input | 1 | Begin a request (accepted in IDLE) |
| src_cnt | input | CNT_W | Number of source entries |
| dst_cnt | input | CNT_W | Number of destination entries |
| busy | output | 1 | Request in progress |
| total_valid | output | 1 | One-cycle strobe for total_cnt |
| total_cnt | output | SUM_W | Descriptors in the stream |
| d_valid | output | 1 | Descriptor available |
| d_ready | input | 1 | Consumer accepts descriptor |
| d_data | output | 64 | Descriptor word |
| done | output | 1 | One-cycle end-of-request strobe |
| req_err | output | 1 | One-cycle rejection strobe |

## Verification
Take the clock edge that samples `start` as edge 0 and let N be the number of entries in the request. `total_valid`, or `req_err` with `done` for a length violation, appears after edge N. A count overflow is reported after edge 0. The first descriptor is valid one cycle after the total, each accepted descriptor is replaced on the next cycle, and `done` follows one cycle after the last handshake. The reference model in the bench builds the expected descriptor queue behaviourally and counts cycles from the start edge. Every cycle it compares the flags and the head of the queue at the falling edge, half a period away from the edge where the design updates.

// File: rtl/sgde_pkg.sv
package sgde_pkg;
    localparam int DESC_W       = 64;
    localparam int ADDR_FIELD_W = 44;
    localparam int LEN_FIELD_W  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_COUNT,
        ST_EMIT_SRC,
        ST_EMIT_DST,
        ST_FIN,
        ST_FAIL
    } sgde_state_e;
endpackage

// File: rtl/sgde_list_mem.sv
module sgde_list_mem #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 48,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LEN_W-1:0]  wlen,
    input  logic [IDX_W-1:0]  ridx,
    output logic [ADDR_W-1:0] raddr,
    output logic [LEN_W-1:0]  rlen
);
    logic [ADDR_W-1:0] addr_mem [DEPTH];
    logic [LEN_W-1:0]  len_mem  [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(widx) < DEPTH)) begin
            addr_mem[widx] <= waddr;
            len_mem[widx]  <= wlen;
        end
    end

    always_comb begin
        raddr = addr_mem[ridx];
        rlen  = len_mem[ridx];
    end
endmodule

// File: rtl/sgde_fmt.sv
module sgde_fmt
    import sgde_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int LEN_W  = 32
) (
    input  logic              is_dst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic [DESC_W-1:0] word,
    output logic              legal
);
    localparam logic [LEN_W-1:0] FIELD_MAX = LEN_W'((1 << LEN_FIELD_W) - 1);

    logic                   mega;
    logic [LEN_W-1:0]       units;
    logic [LEN_FIELD_W-1:0] field;

    always_comb begin
        mega  = (len[3:0] == 4'd0);
        units = len >> 4;
        field = mega ? units[LEN_FIELD_W-1:0] : len[LEN_FIELD_W-1:0];
        legal = mega ? (units <= FIELD_MAX) : (len <= FIELD_MAX);
        // type nibble: 0,mega,1,dst -> 2/3 byte form, 6/7 unit form
        word  = {1'b0, mega, 1'b1, is_dst, field, addr[ADDR_FIELD_W-1:0]};
    end
endmodule

// File: rtl/sg_desc_encoder.sv
module sg_desc_encoder
    import sgde_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 48,
    parameter int LEN_W  = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SUM_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic              start,
    input  logic [CNT_W-1:0]  src_cnt,
    input  logic [CNT_W-1:0]  dst_cnt,
    output logic              busy,
    output logic              total_valid,
    output logic [SUM_W-1:0]  total_cnt,
    output logic              d_valid,
    input  logic              d_ready,
    output logic [DESC_W-1:0] d_data,
    output logic              done,
    output logic              req_err
);
    sgde_state_e state_q, state_d;

    logic [CNT_W-1:0] si_q, di_q, scnt_q, dcnt_q;
    logic [SUM_W-1:0] scan_q, tot_q;
    logic [LEN_W-1:0] tgt_q;
    logic             bad_q;

    logic [IDX_W-1:0]  ridx  [2];
    logic [ADDR_W-1:0] raddr [2];
    logic [LEN_W-1:0]  rlen  [2];
    logic [DESC_W-1:0] word  [2];
    logic              legal [2];
    logic              we    [2];

    logic             scan_in_src, scan_last, entry_ok, cnt_over;
    logic [LEN_W-1:0] tgt_after_dst;

    // ---------------- list storage and per-list formatters ----------------
    generate
        for (genvar g = 0; g < 2; g++) begin : g_list
            assign we[g] = wr_en && (wr_sel == 1'(g)) && (state_q == ST_IDLE);

            sgde_list_mem #(
                .DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
            ) u_mem (
                .clk  (clk),
                .we   (we[g]),
                .widx (wr_idx),
                .waddr(wr_addr),
                .wlen (wr_len),
                .ridx (ridx[g]),
                .raddr(raddr[g]),
                .rlen (rlen[g])
            );

            sgde_fmt #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fmt (
                .is_dst(1'(g)),
                .addr  (raddr[g]),
                .len   (rlen[g]),
                .word  (word[g]),
                .legal (legal[g])
            );
        end
    endgenerate

    // ---------------- read addressing and scan helpers ----------------
    always_comb begin
        scan_in_src = (scan_q < SUM_W'(scnt_q));
        scan_last   = (scan_q == tot_q - SUM_W'(1));
        entry_ok    = scan_in_src ? legal[0] : legal[1];
        cnt_over    = (src_cnt > CNT_W'(DEPTH)) || (dst_cnt > CNT_W'(DEPTH));
        if (state_q == ST_SCAN) begin
            ridx[0] = IDX_W'(scan_q);
            ridx[1] = IDX_W'(scan_q - SUM_W'(scnt_q));
        end else begin
            ridx[0] = IDX_W'(si_q);
            ridx[1] = IDX_W'(di_q);
        end
        tgt_after_dst = (rlen[1] < tgt_q) ? (tgt_q - rlen[1]) : '0;
    end

    // Choose what follows: a destination while bytes remain (or sources are
    // exhausted), else the next source, else the end of the request.
    function automatic sgde_state_e pick(input logic [CNT_W-1:0] si,
                                         input logic [CNT_W-1:0] di,
                                         input logic [LEN_W-1:0] tgt);
        if ((di < dcnt_q) && ((tgt != '0) || (si == scnt_q)))
            return ST_EMIT_DST;
        else if (si < scnt_q)
            return ST_EMIT_SRC;
        else
            return ST_FIN;
    endfunction

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (cnt_over)
                        state_d = ST_FAIL;
                    else if ((src_cnt == '0) && (dst_cnt == '0))
                        state_d = ST_COUNT;
                    else
                        state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (scan_last)
                    state_d = (bad_q || !entry_ok) ? ST_FAIL : ST_COUNT;
            end
            ST_COUNT:    state_d = pick('0, '0, '0);
            ST_EMIT_SRC: if (d_ready) state_d = pick(CNT_W'(si_q + 1'b1), di_q, rlen[0]);
            ST_EMIT_DST: if (d_ready) state_d = pick(si_q, CNT_W'(di_q + 1'b1), tgt_after_dst);
            ST_FIN:      state_d = ST_IDLE;
            ST_FAIL:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- walk registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            si_q   <= '0;
            di_q   <= '0;
            scnt_q <= '0;
            dcnt_q <= '0;
            scan_q <= '0;
            tot_q  <= '0;
            tgt_q  <= '0;
            bad_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        scnt_q <= src_cnt;
                        dcnt_q <= dst_cnt;
                        tot_q  <= SUM_W'(src_cnt) + SUM_W'(dst_cnt);
                        scan_q <= '0;
                        bad_q  <= 1'b0;
                        si_q   <= '0;
                        di_q   <= '0;
                        tgt_q  <= '0;
                    end
                end
                ST_SCAN: begin
                    scan_q <= scan_q + SUM_W'(1);
                    bad_q  <= bad_q | ~entry_ok;
                end
                ST_EMIT_SRC: begin
                    if (d_ready) begin
                        si_q  <= CNT_W'(si_q + 1'b1);
                        tgt_q <= rlen[0];
                    end
                end
                ST_EMIT_DST: begin
                    if (d_ready) begin
                        di_q  <= CNT_W'(di_q + 1'b1);
                        tgt_q <= tgt_after_dst;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy        = (state_q != ST_IDLE);
        total_valid = (state_q == ST_COUNT);
        total_cnt   = tot_q;
        d_valid     = (state_q == ST_EMIT_SRC) || (state_q == ST_EMIT_DST);
        d_data      = (state_q == ST_EMIT_DST) ? word[1] : word[0];
        done        = (state_q == ST_FIN) || (state_q == ST_FAIL);
        req_err     = (state_q == ST_FAIL);
    end

    // ---------------- assertions ----------------
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_ready) |=> (d_valid && $stable(d_data)));

    a_r7_total_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_valid) |-> $past(total_valid));

    a_r1_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |-> (d_data[63:60] inside {4'd2, 4'd3, 4'd6, 4'd7}));

    a_r4_err_ends: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> (!busy && !d_valid));

    a_r10_no_silent_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!d_valid && !total_valid));
endmodule

// File: tb/tb_sg_desc_encoder.sv
module tb_sg_desc_encoder;
    localparam int DEPTH = 8;
    localparam int CNT_W = 4;
    localparam int IDX_W = 3;
    localparam int SUM_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0, wr_sel = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [47:0]       wr_addr = '0;
    logic [31:0]       wr_len = '0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  src_cnt = '0, dst_cnt = '0;
    logic              busy, total_valid, d_valid, done, req_err;
    logic              d_ready = 1'b1;
    logic [SUM_W-1:0]  total_cnt;
    logic [63:0]       d_data;

    sg_desc_encoder #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_addr(wr_addr), .wr_len(wr_len), .start(start), .src_cnt(src_cnt),
        .dst_cnt(dst_cnt), .busy(busy), .total_valid(total_valid),
        .total_cnt(total_cnt), .d_valid(d_valid), .d_ready(d_ready),
        .d_data(d_data), .done(done), .req_err(req_err)
    );

    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    logic [47:0] sa [16];
    logic [47:0] da [16];
    int unsigned sl [16];
    int unsigned dl [16];
    int ns, nd;
    logic [63:0] expq [$];
    bit exp_err, cnt_err;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] enc(input bit dst, input logic [47:0] a,
                                        input int unsigned l);
        logic [3:0]  t;
        logic [15:0] f;
        if (l % 16 == 0) begin t = dst ? 4'd7 : 4'd6; f = 16'(l / 16); end
        else             begin t = dst ? 4'd3 : 4'd2; f = 16'(l);      end
        return {t, f, a[43:0]};
    endfunction

    function automatic bit bad_len(input int unsigned l);
        if (l % 16 != 0) return l > 32'hFFFF;
        return l > 32'hFFFF0;
    endfunction

    // behavioural reference: expected descriptor list and error verdict
    task automatic build_model();
        int s, d;
        longint tgt;
        bit unl;
        expq.delete();
        cnt_err = (ns > DEPTH) || (nd > DEPTH);
        exp_err = cnt_err;
        if (!cnt_err) begin
            for (int i = 0; i < ns; i++) if (bad_len(sl[i])) exp_err = 1;
            for (int i = 0; i < nd; i++) if (bad_len(dl[i])) exp_err = 1;
        end
        if (exp_err) return;
        s = 0; d = 0;
        while (s < ns || d < nd) begin
            unl = 0;
            tgt = 0;
            if (s < ns) begin
                expq.push_back(enc(0, sa[s], sl[s]));
                tgt = sl[s];
                s++;
            end else unl = 1;
            while ((unl || tgt != 0) && d < nd) begin
                expq.push_back(enc(1, da[d], dl[d]));
                if (!unl) tgt = (dl[d] < tgt) ? tgt - dl[d] : 0;
                d++;
            end
        end
    endtask

    task automatic put(input bit sel, input int idx, input logic [47:0] a,
                       input int unsigned l);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_idx = IDX_W'(idx); wr_addr = a; wr_len = l;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic load();
        for (int i = 0; i < ns && i < DEPTH; i++) put(0, i, sa[i], sl[i]);
        for (int i = 0; i < nd && i < DEPTH; i++) put(1, i, da[i], dl[i]);
    endtask

    task automatic run(input string tag, input bit bp, input bit tamper);
        int n_ent, k, exp_tot;
        bit fin;
        build_model();
        load();
        exp_tot = expq.size();
        n_ent = cnt_err ? 0 : ns + nd;
        @(negedge clk);
        start = 1; src_cnt = CNT_W'(ns); dst_cnt = CNT_W'(nd);
        @(negedge clk);
        start = 0;
        k = 0;
        fin = 0;
        while (!fin && k < 2000) begin
            wr_en = 0;
            start = 0;
            d_ready = bp ? ((k % 3) != 2) : 1'b1;
            if (tamper && k == n_ent + 1) begin
                // R10: writes and start while busy must change nothing
                wr_en = 1; wr_sel = 0; wr_idx = IDX_W'(ns - 1);
                wr_addr = 48'h0; wr_len = 32'd3;
                start = 1; src_cnt = 4'd1; dst_cnt = 4'd1;
            end
            if (k < n_ent) begin
                chk({busy, total_valid, d_valid, done} == 4'b1000,
                    {tag, " R7 scan phase flags"},
                    64'({busy, total_valid, d_valid, done}), 64'h8);
            end else if (k == n_ent) begin
                if (exp_err) begin
                    chk(req_err && done && !total_valid && !d_valid,
                        {tag, " R4 rejection"},
                        64'({req_err, done, total_valid, d_valid}), 64'hC);
                    fin = 1;
                end else begin
                    chk(total_valid && !d_valid && (int'(total_cnt) == exp_tot),
                        {tag, " R7 total"}, 64'(total_cnt), 64'(exp_tot));
                end
            end else if (expq.size() > 0) begin
                chk(d_valid && (d_data == expq[0]),
                    {tag, " R5/R6 descriptor (R1 R2 R3 R9)"}, d_data, expq[0]);
                if (d_valid && d_ready) void'(expq.pop_front());
            end else begin
                chk(done && !req_err && !d_valid, {tag, " R8 end of request"},
                    64'({done, req_err, d_valid}), 64'h4);
                fin = 1;
            end
            @(negedge clk);
            k++;
        end
        wr_en = 0; start = 0; d_ready = 1;
        chk(!busy && !d_valid, {tag, " R10 back to idle"}, 64'({busy, d_valid}), 64'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, d_valid, total_valid, done, req_err} == 5'b0, "R11 reset state",
            64'({busy, d_valid, total_valid, done, req_err}), 64'h0);
        rst_n = 1;
        @(negedge clk);
        chk({busy, d_valid, total_valid, done, req_err} == 5'b0, "R11 after release",
            64'({busy, d_valid, total_valid, done, req_err}), 64'h0);

        // R3 R5: unit-form source, two unit-form destinations
        ns = 1; nd = 2;
        sa[0] = 48'hF123_4567_89A0; sl[0] = 48;
        da[0] = 48'h0000_0000_1000; dl[0] = 16;
        da[1] = 48'hA000_0000_2000; dl[1] = 32;
        run("T1", 0, 0);

        // R1 R2 R5: byte-form, shorter then equal destinations
        ns = 2; nd = 3;
        sa[0] = 48'h1111_2222_3333; sl[0] = 100;
        sa[1] = 48'h4444_5555_6666; sl[1] = 37;
        da[0] = 48'h7777_8888_9999; dl[0] = 50;
        da[1] = 48'hAAAA_BBBB_CCCC; dl[1] = 50;
        da[2] = 48'hDDDD_EEEE_FFFF; dl[2] = 37;
        run("T2", 0, 0);

        // R9: same request under back-pressure
        run("T2bp", 1, 0);

        // R10: writes and start during the stream are ignored
        run("T2busy", 1, 1);

        // R6: leftover destinations after sources run out
        ns = 1; nd = 4;
        sa[0] = 48'h0000_0000_0100; sl[0] = 10;
        da[0] = 48'h0000_0000_0200; dl[0] = 5;
        da[1] = 48'h0000_0000_0300; dl[1] = 5;
        da[2] = 48'h0000_0000_0400; dl[2] = 7;
        da[3] = 48'h0000_0000_0500; dl[3] = 9;
        run("T3", 0, 0);

        // R5: longer destination clears the target; second source has none
        ns = 2; nd = 1;
        sa[0] = 48'h0000_0001_0000; sl[0] = 20;
        sa[1] = 48'h0000_0002_0000; sl[1] = 20;
        da[0] = 48'h0000_0003_0000; dl[0] = 64;
        run("T4", 0, 0);

        // R3: zero-length source encodes as unit form with count 0
        ns = 1; nd = 1;
        sa[0] = 48'h0000_0000_0AB0; sl[0] = 0;
        da[0] = 48'h0000_0000_0CD0; dl[0] = 16;
        run("T5", 0, 0);

        // R6: destinations only
        ns = 0; nd = 2;
        da[0] = 48'h5000_0000_0010; dl[0] = 3;
        da[1] = 48'h6000_0000_0020; dl[1] = 160;
        run("T6", 0, 0);

        // R8: empty request
        ns = 0; nd = 0;
        run("T7", 0, 0);

        // R4 boundary: largest legal lengths in both forms
        ns = 1; nd = 1;
        sa[0] = 48'h0000_0000_1234; sl[0] = 32'hFFFF;
        da[0] = 48'h0000_0000_5670; dl[0] = 32'hFFFF0;
        run("T8", 0, 0);

        // R4: byte-form length one past the limit
        ns = 1; nd = 1;
        sa[0] = 48'h0; sl[0] = 32'h10001;
        da[0] = 48'h0; dl[0] = 5;
        run("T9", 0, 0);

        // R4: unit-form length one unit past the limit
        ns = 1; nd = 1;
        sa[0] = 48'h0; sl[0] = 32;
        da[0] = 48'h0; dl[0] = 32'h100000;
        run("T10", 0, 0);

        // R4: source count above the list depth
        ns = 9; nd = 0;
        run("T11", 0, 0);

        // recovery after rejection
        ns = 1; nd = 1;
        sa[0] = 48'h0000_0000_0777; sl[0] = 7;
        da[0] = 48'h0000_0000_0888; dl[0] = 7;
        run("T12", 1, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule